// File: doc/BRIEF.md
# Peak-Current Phase-Shift PWM Leg

This block drives the four gates of a full bridge run under peak current control. One leg, called the fixed leg, switches at a steady 50% duty with dead time. The other leg, called the controlled leg, switches at the instants a current-sense comparator reports that the primary current has reached its commanded peak. Where those crossings fall in each half cycle sets the phase shift between the two legs, and the phase shift sets how much energy is passed to the secondary. Compare registers do not set the switching edges.

A symmetric up-down counter gives the timebase. It runs from zero up to a programmed period and back to zero. An action stage turns counter events and direction-qualified comparator events into a raw drive level for each leg. A dead-band stage per leg produces the complementary A/B pair, with a rising-edge delay on A and a falling-edge delay on the inverted B. A cycle-by-cycle trip latch pulls the gate that must turn off low one clock ahead of the dead-band path. The latch is released at every turnaround of the counter. The period and both dead-band delays are double-buffered and take effect only at the zero count.

Top module: `pspwm_leg`

## Requirements
- R1: While reset is high, and on the first clock after it, all four gate outputs are low. The counter starts at zero and counts up, so one full switching period is 2*PRD clocks, with PRD >= 2.
- R2: The raw level of the fixed leg goes high at the clock after the zero count and low at the clock after the period count. This gives exactly PRD clocks high and PRD clocks low.
- R3: Each gate pair lags its raw level by one clock. A is high after an edge exactly when the raw level was high on the previous RED+1 edges. B is high exactly when the raw level was low on the previous FED+1 edges. A and B are never both high.
- R4: The raw level of the controlled leg is set high by a comparator event seen while counting up. It is also set high by the period count.
- R5: The raw level of the controlled leg is set low by a comparator event seen while counting down. The cycle at the period count counts as down. The raw level is also set low by the zero count.
- R6: The comparator input passes through a two-flop synchronizer and a rising-edge detector. An event acts at the second clock edge after the edge that first samples the input high. An input held high gives only one event.
- R7: A down-count event forces controlled A low at the edge that acts on it. An up-count event forces controlled B low the same way. Both take effect one clock before the dead-band path would turn the gate off.
- R8: The trip force holds until the next zero count or period count. It releases at the edge that acts on that count.
- R9: A new period or new dead-band delays presented at the inputs take effect only at the edge where the counter is at zero. Before that, the running period and dead times keep their old values.
- R10: A zero or period count acting at the same edge as a comparator event takes priority over the event, both for the raw level and for the trip latch.
- R11: The dead-band run counters saturate. A delay equal to the largest value the DW-bit field can hold still works inside long periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prd_i | input | CW | Counter turnaround value (PRD), double-buffered |
| red_i | input | DW | Rising-edge delay for A outputs (RED), double-buffered |
| fed_i | input | DW | Falling-edge delay for B outputs (FED), double-buffered |
| cmp_i | input | 1 | Current comparator output, asynchronous |
| ctl_a_o | output | 1 | Controlled leg, gate A |
| ctl_b_o | output | 1 | Controlled leg, gate B |
| fix_a_o | output | 1 | Fixed leg, gate A |
| fix_b_o | output | 1 | Fixed leg, gate B |

## Verification
The bench builds the block with CW=8 and DW=4. This keeps periods short, so every comparator phase, both turnarounds and period changes fit in a few hundred clocks. The 4-bit delay field saturates at 15. A 40-count period therefore runs the dead-band counters into saturation at the largest delay. Comparator pulses are timed so that they land in each half cycle, exactly on the zero and period counts, and held across many clocks.

// File: rtl/pspwm_pkg.sv
package pspwm_pkg;

  // Leg indices into per-leg vectors
  localparam int unsigned LEGS    = 2;
  localparam int unsigned IDX_CTL = 0;
  localparam int unsigned IDX_FIX = 1;

  // Timebase events decoded from the counter state
  typedef struct packed {
    logic zero;  // counter sits at zero
    logic top;   // counter sits at the period value
    logic up;    // counting up (false at the top)
  } tb_evt_t;

endpackage

// File: rtl/pspwm_counter.sv
module pspwm_counter
  import pspwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] prd_i,
  output tb_evt_t       evt_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] prd_sh;
  logic          up_q;
  logic [CW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      prd_sh <= prd_i;
    end else begin
      if (cnt_q == '0) prd_sh <= prd_i;
      if (up_q) begin
        if (cnt_inc >= {1'b0, prd_sh}) begin
          cnt_q <= prd_sh;
          up_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_inc[CW-1:0];
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_q <= '0;
          up_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign evt_o.zero = (cnt_q == '0);
  assign evt_o.top  = (cnt_q == prd_sh);
  assign evt_o.up   = up_q;

  // R1: count never leaves the range 0..period
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= prd_sh);

  // R1: at the top the counter is already heading down
  assert_top_is_down_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == prd_sh) |-> !up_q);

  // R9: period shadow only moves at the zero count
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(prd_sh));

endmodule

// File: rtl/pspwm_trip_sync.sv
module pspwm_trip_sync (
  input  logic clk,
  input  logic rst,
  input  logic cmp_i,
  output logic evt_o
);

  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[1:0], cmp_i};
  end

  assign evt_o = sh_q[1] & ~sh_q[2];

  // R6: an event never lasts more than one clock
  assert_one_shot_R6: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);

endmodule

// File: rtl/pspwm_deadband.sv
module pspwm_deadband #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw_i,
  input  logic [DW-1:0] red_i,
  input  logic [DW-1:0] fed_i,
  output logic          a_o,
  output logic          b_o
);

  localparam logic [DW-1:0] RUN_MAX = '1;

  logic [DW-1:0] hi_run, lo_run;
  logic          a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      lo_run <= '0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
    end else begin
      if (raw_i) hi_run <= (hi_run == RUN_MAX) ? hi_run : hi_run + 1'b1;
      else       hi_run <= '0;
      if (!raw_i) lo_run <= (lo_run == RUN_MAX) ? lo_run : lo_run + 1'b1;
      else        lo_run <= '0;
      a_q <= raw_i && (hi_run >= red_i);
      b_q <= !raw_i && (lo_run >= fed_i);
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;

  // R3: the pair is never on together
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(a_o && b_o));

  // R3: A only turns on after a high raw level
  assert_a_follows_raw_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(a_o) |-> $past(raw_i));

endmodule

// File: rtl/pspwm_leg.sv
module pspwm_leg
  import pspwm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] prd_i,
  input  logic [DW-1:0] red_i,
  input  logic [DW-1:0] fed_i,
  input  logic          cmp_i,
  output logic          ctl_a_o,
  output logic          ctl_b_o,
  output logic          fix_a_o,
  output logic          fix_b_o
);

  tb_evt_t         ev;
  logic            trip_evt, trip_up, trip_dn;
  logic [DW-1:0]   red_sh, fed_sh;
  logic [LEGS-1:0] raw_q;
  logic [LEGS-1:0] db_a, db_b;
  logic            lat_a, lat_b;

  pspwm_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .prd_i (prd_i),
    .evt_o (ev)
  );

  pspwm_trip_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .cmp_i (cmp_i),
    .evt_o (trip_evt)
  );

  assign trip_up = trip_evt &  ev.up;
  assign trip_dn = trip_evt & ~ev.up;

  always_ff @(posedge clk) begin
    if (rst) begin
      red_sh <= red_i;
      fed_sh <= fed_i;
      raw_q  <= '0;
      lat_a  <= 1'b0;
      lat_b  <= 1'b0;
    end else begin
      if (ev.zero) begin
        red_sh <= red_i;
        fed_sh <= fed_i;
      end
      // fixed leg: half period high, half low
      if (ev.zero)     raw_q[IDX_FIX] <= 1'b1;
      else if (ev.top) raw_q[IDX_FIX] <= 1'b0;
      // controlled leg: counter events first, then comparator
      if (ev.zero)     raw_q[IDX_CTL] <= 1'b0;
      else if (ev.top) raw_q[IDX_CTL] <= 1'b1;
      else if (trip_up) raw_q[IDX_CTL] <= 1'b1;
      else if (trip_dn) raw_q[IDX_CTL] <= 1'b0;
      // cycle-by-cycle trip latch
      if (ev.zero || ev.top) begin
        lat_a <= 1'b0;
        lat_b <= 1'b0;
      end else begin
        if (trip_dn) lat_a <= 1'b1;
        if (trip_up) lat_b <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_db
    pspwm_deadband #(.DW(DW)) u_db (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_q[g]),
      .red_i (red_sh),
      .fed_i (fed_sh),
      .a_o   (db_a[g]),
      .b_o   (db_b[g])
    );
  end

  assign ctl_a_o = db_a[IDX_CTL] & ~lat_a;
  assign ctl_b_o = db_b[IDX_CTL] & ~lat_b;
  assign fix_a_o = db_a[IDX_FIX];
  assign fix_b_o = db_b[IDX_FIX];

  // R2: fixed leg raw rises right after the zero count
  assert_fix_rise_R2: assert property (@(posedge clk) disable iff (rst)
    ev.zero |=> raw_q[IDX_FIX]);

  // R4, R10: period count drives the controlled raw level high
  assert_top_sets_R4: assert property (@(posedge clk) disable iff (rst)
    ev.top |=> raw_q[IDX_CTL]);

  // R5, R10: zero count drives the controlled raw level low
  assert_zero_clears_R5: assert property (@(posedge clk) disable iff (rst)
    ev.zero |=> !raw_q[IDX_CTL]);

  // R7: a down-count trip turns controlled A off at once
  assert_trip_dn_a_R7: assert property (@(posedge clk) disable iff (rst)
    (trip_dn && !ev.zero && !ev.top) |=> !ctl_a_o);

  // R7: an up-count trip turns controlled B off at once
  assert_trip_up_b_R7: assert property (@(posedge clk) disable iff (rst)
    (trip_up && !ev.zero && !ev.top) |=> !ctl_b_o);

  // R8: turnarounds release the trip latch
  assert_latch_release_R8: assert property (@(posedge clk) disable iff (rst)
    (ev.zero || ev.top) |=> (!lat_a && !lat_b));

endmodule

// File: tb/pspwm_leg_test.sv
module pspwm_leg_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int NVEC = 7;

  // fields: prd[39:32] red[31:28] fed[27:24] up_off[23:16] dn_off[15:8] cycles[7:0]
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd10, 4'd2, 4'd3, 8'd255, 8'd255, 8'd60},
    {8'd10, 4'd2, 4'd3, 8'd3,   8'd14,  8'd80},
    {8'd12, 4'd1, 4'd1, 8'd6,   8'd18,  8'd72},
    {8'd8,  4'd0, 4'd0, 8'd1,   8'd9,   8'd64},
    {8'd6,  4'd3, 4'd3, 8'd4,   8'd8,   8'd48},
    {8'd20, 4'd5, 4'd4, 8'd7,   8'd30,  8'd120},
    {8'd16, 4'd2, 4'd6, 8'd0,   8'd16,  8'd96}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] prd = 8'd10;
  logic [DW-1:0] red = 4'd2;
  logic [DW-1:0] fed = 4'd3;
  logic          cmp = 1'b0;
  logic          ctl_a, ctl_b, fix_a, fix_b;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pspwm_leg #(.CW(CW), .DW(DW)) uut (
    .clk     (clk),
    .rst     (rst),
    .prd_i   (prd),
    .red_i   (red),
    .fed_i   (fed),
    .cmp_i   (cmp),
    .ctl_a_o (ctl_a),
    .ctl_b_o (ctl_b),
    .fix_a_o (fix_a),
    .fix_b_o (fix_b)
  );

  // Requirement-level reference: phase index, event rules, history windows
  int          m_ph, m_P, m_red, m_fed;
  logic [2:0]  m_c;
  logic        m_rc, m_rf, m_la, m_lb;
  logic [31:0] m_hh [2];
  logic [31:0] m_hl [2];
  logic        m_da [2];
  logic        m_db [2];

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_P = int'(prd); m_red = int'(red); m_fed = int'(fed);
      m_c = '0; m_rc = 0; m_rf = 0; m_la = 0; m_lb = 0;
      for (int l = 0; l < 2; l++) begin
        m_hh[l] = '0; m_hl[l] = '0; m_da[l] = 0; m_db[l] = 0;
      end
    end else begin
      logic zero, topc, upd, ev, tu, td;
      logic [31:0] ma, mb;
      zero = (m_ph == 0);
      topc = (m_ph == m_P);
      upd  = (m_ph < m_P);
      ev   = m_c[1] & ~m_c[2];
      tu   = ev & upd;
      td   = ev & ~upd;
      ma = (32'd1 << (m_red + 1)) - 32'd1;
      mb = (32'd1 << (m_fed + 1)) - 32'd1;
      m_hh[0] = {m_hh[0][30:0], m_rc};  m_hl[0] = {m_hl[0][30:0], ~m_rc};
      m_hh[1] = {m_hh[1][30:0], m_rf};  m_hl[1] = {m_hl[1][30:0], ~m_rf};
      for (int l = 0; l < 2; l++) begin
        m_da[l] = ((m_hh[l] & ma) == ma);
        m_db[l] = ((m_hl[l] & mb) == mb);
      end
      if (zero) m_rf = 1; else if (topc) m_rf = 0;
      if (zero) m_rc = 0; else if (topc) m_rc = 1; else if (tu) m_rc = 1; else if (td) m_rc = 0;
      if (zero || topc) begin m_la = 0; m_lb = 0; end
      else begin if (td) m_la = 1; if (tu) m_lb = 1; end
      if (zero) begin
        m_P = int'(prd); m_red = int'(red); m_fed = int'(fed);
        m_ph = 1;
      end else begin
        m_ph = (m_ph + 1 == 2 * m_P) ? 0 : m_ph + 1;
      end
      m_c = {m_c[1:0], cmp};
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string nm);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(fix_a, m_da[1], {tag, " R2 R3"}, "fix_a");
    chk(fix_b, m_db[1], {tag, " R2 R3"}, "fix_b");
    chk(ctl_a, m_da[0] & ~m_la, {tag, " R4 R5 R7"}, "ctl_a");
    chk(ctl_b, m_db[0] & ~m_lb, {tag, " R4 R5 R7"}, "ctl_b");
  endtask

  // one negedge per cycle: check outputs, then drive the comparator
  task automatic run_seg(input int n, input int o1, input int o2, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_all(tag);
      cmp = (m_ph == o1) || (m_ph == o2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(ctl_a, 1'b0, "R1", "ctl_a"); chk(ctl_b, 1'b0, "R1", "ctl_b");
      chk(fix_a, 1'b0, "R1", "fix_a"); chk(fix_b, 1'b0, "R1", "fix_b");
    end
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_a, 1'b0, "R1", "ctl_a first"); chk(fix_a, 1'b0, "R1", "fix_a first");
    chk(fix_b, 1'b0, "R1", "fix_b first"); chk(ctl_b, 1'b0, "R1", "ctl_b first");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      prd = VEC[v][39:32];
      red = VEC[v][31:28];
      fed = VEC[v][27:24];
      run_seg(int'(VEC[v][7:0]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), "table");
    end

    // R10: events landing exactly on the period and zero counts
    prd = 8'd10; red = 4'd1; fed = 4'd2;
    run_seg(60, 8, 18, "R10");

    // R8: down trip early in the fall, held until zero
    run_seg(60, 255, 11, "R8");

    // R6: comparator held high across many clocks
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk_all("R6");
      cmp = (i >= 5 && i < 25);
    end

    // R9: change period and delays mid-count
    run_seg(4, 255, 255, "R9");
    prd = 8'd5; red = 4'd0; fed = 4'd1;
    run_seg(50, 2, 7, "R9");

    // R11: long period with the largest delays
    prd = 8'd40; red = 4'd15; fed = 4'd15;
    run_seg(240, 30, 60, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule